// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets a host reach a switch's 32-bit internal registers over a management bus that only moves 16 bits per transaction. The host presents an 18-bit byte address, a read or write flag and, for writes, 32 bits of data. The bridge then runs a fixed series of management transactions and reports completion with a one-cycle done pulse.

Each access begins by selecting a page. It then waits a settle interval and moves the two 16-bit halves. The PHY address and register number of the halves come from the middle address bits. Only one request is in flight at a time: the host port stays not-ready from acceptance until completion. A helper flag marks a read that returned all ones, which usually means no device is answering.

The management port is transaction level. The bridge pulses `mgmt_start` with the fields set and holds those fields constant. The bus side raises `mgmt_busy` on the next clock and drops it once the transaction is finished. On a read, `mgmt_rdata` must be valid from the first cycle in which busy is low.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, `host_ready` is 1 and `host_done`, `host_all_ones` and `mgmt_start` are 0.
- R2: The first transaction of every access is a write to PHY address 0x18, register 0, with data equal to byte address bits [17:9], zero-extended to 16 bits.
- R3: The transaction after the page write starts exactly SETTLE_CYCLES+2 clock edges after the edge on which `mgmt_busy` fell for the page write. This leaves at least SETTLE_CYCLES idle cycles.
- R4: Both data transactions use PHY address 0x10 OR address bits [8:6]. The low half uses register number {addr[5:2],0} and the high half uses that number plus one.
- R5: A read fetches the low register first and the high register second, and returns {high, low} on `host_rdata`.
- R6: A write sends `host_wdata[31:16]` to the high register first, then `host_wdata[15:0]` to the low register.
- R7: `host_ready` is 0 from the cycle after acceptance until `host_done`. `host_done` is a single-cycle pulse two edges after busy falls on the last transaction, and ready is 1 again in the following cycle.
- R8: `mgmt_start` lasts one cycle and is only raised while `mgmt_busy` is 0. The second data transaction starts two edges after the first one completes.
- R9: PHY address, register, write data and direction are held stable while `mgmt_busy` is 1.
- R10: `host_all_ones` is 1 only in the done cycle of a read whose result is 0xFFFFFFFF.
- R11: Byte address bits [1:0] do not affect any transaction or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Bridge can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read result, valid with done |
| host_done | output | 1 | One-cycle completion pulse |
| host_all_ones | output | 1 | Read result was all ones |
| mgmt_start | output | 1 | Start one management transaction |
| mgmt_busy | input | 1 | Transaction in progress |
| mgmt_write | output | 1 | Transaction direction |
| mgmt_phy | output | 5 | PHY address |
| mgmt_reg | output | 5 | Register number |
| mgmt_wdata | output | 16 | Transaction write data |
| mgmt_rdata | input | 16 | Transaction read data |

## Verification
The bench builds the bridge with SETTLE_CYCLES set to 12 instead of the millisecond default. This makes the exact edge count of the settle gap observable in a short run, while keeping it far larger than the bus latency, so a shortened or skipped wait cannot go unnoticed. The bus model's latency rotates through one to four busy cycles, so completion timing, done placement and read capture are exercised against several handshake lengths. Pages 0x000, 0x0AB, 0x155 and the absent page 0x1FF are used, along with sub-address and register extremes.

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int          CLK_HZ        = 50_000_000,
  parameter int          SETTLE_CYCLES = CLK_HZ / 1000,
  parameter logic [4:0]  PAGE_PHY      = 5'h18,
  parameter logic [4:0]  DATA_PHY      = 5'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic [17:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_done,
  output logic        host_all_ones,
  output logic        mgmt_start,
  input  logic        mgmt_busy,
  output logic        mgmt_write,
  output logic [4:0]  mgmt_phy,
  output logic [4:0]  mgmt_reg,
  output logic [15:0] mgmt_wdata,
  input  logic [15:0] mgmt_rdata
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_SETTLE, S_FIN} state_t;

  state_t      st;
  logic [1:0]  ph;
  logic [17:0] addr_q;
  logic [31:0] wdata_q;
  logic        wr_q;
  logic [15:0] lo_q;
  logic [31:0] rdata_q;
  logic [CW-1:0] cnt;

  logic [4:0] lo_reg, hi_reg, data_phy;
  logic       use_hi;

  assign lo_reg   = {addr_q[5:2], 1'b0};
  assign hi_reg   = {addr_q[5:2], 1'b1};
  assign data_phy = DATA_PHY | {2'b00, addr_q[8:6]};
  assign use_hi   = (ph == 2'd1) ? wr_q : !wr_q;

  assign mgmt_start = (st == S_ISSUE);
  assign mgmt_write = (ph == 2'd0) || wr_q;
  assign mgmt_phy   = (ph == 2'd0) ? PAGE_PHY : data_phy;
  assign mgmt_reg   = (ph == 2'd0) ? 5'd0 : (use_hi ? hi_reg : lo_reg);
  assign mgmt_wdata = (ph == 2'd0) ? {7'd0, addr_q[17:9]}
                    : (use_hi ? wdata_q[31:16] : wdata_q[15:0]);

  assign host_ready    = (st == S_IDLE);
  assign host_done     = (st == S_FIN);
  assign host_rdata    = rdata_q;
  assign host_all_ones = (st == S_FIN) && !wr_q && (&rdata_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= 2'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      lo_q    <= '0;
      rdata_q <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (host_valid) begin
          addr_q  <= host_addr;
          wdata_q <= host_wdata;
          wr_q    <= host_write;
          ph      <= 2'd0;
          st      <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (!mgmt_busy) begin
          case (ph)
            2'd0: begin
              cnt <= CW'(SETTLE_CYCLES - 1);
              st  <= S_SETTLE;
            end
            2'd1: begin
              if (!wr_q) lo_q <= mgmt_rdata;
              ph <= 2'd2;
              st <= S_ISSUE;
            end
            default: begin
              if (!wr_q) rdata_q <= {mgmt_rdata, lo_q};
              st <= S_FIN;
            end
          endcase
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            ph <= 2'd1;
            st <= S_ISSUE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_ready |=> mgmt_start && mgmt_phy == PAGE_PHY && mgmt_reg == 5'd0 && mgmt_write); // R2
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_ready |=> !host_ready); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done && host_ready); // R7
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_start |-> !mgmt_busy); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_start |=> !mgmt_start); // R8
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_busy |-> $stable(mgmt_phy) && $stable(mgmt_reg) && $stable(mgmt_wdata) && $stable(mgmt_write)); // R9
  AST_ONES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    host_all_ones |-> host_done); // R10

endmodule

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int S = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [17:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_done;
  logic        host_all_ones;
  logic        mgmt_start;
  logic        mgmt_busy;
  logic        mgmt_write;
  logic [4:0]  mgmt_phy;
  logic [4:0]  mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic [15:0] mgmt_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_page_bridge #(.CLK_HZ(12_000), .SETTLE_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .host_all_ones(host_all_ones),
    .mgmt_start(mgmt_start), .mgmt_busy(mgmt_busy), .mgmt_write(mgmt_write),
    .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
    .mgmt_rdata(mgmt_rdata)
  );

  typedef struct { logic [4:0] phy; logic [4:0] rg; logic [15:0] wd; logic wr; int edge_n; } txn_t;

  int          cyc = 0;
  txn_t        log_q[$];
  int          fall_q[$];
  logic [15:0] mem [int];
  logic [8:0]  dev_page = '0;
  int          nstart = 0;
  int          lat = 0;
  txn_t        cur;

  function automatic logic [15:0] dev_peek(logic [8:0] pg, logic [4:0] phy, logic [4:0] rg);
    int key;
    key = int'({pg, phy, rg});
    if (pg == 9'h1FF) return 16'hFFFF;
    if (mem.exists(key)) return mem[key];
    return 16'(key * 40503) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mgmt_busy  <= 1'b0;
      mgmt_rdata <= '0;
    end else if (mgmt_busy) begin
      if (lat == 0) begin
        mgmt_busy <= 1'b0;
        fall_q.push_back(cyc);
        if (cur.wr) begin
          if (cur.phy == 5'h18 && cur.rg == 5'd0) dev_page <= cur.wd[8:0];
          else mem[int'({dev_page, cur.phy, cur.rg})] = cur.wd;
        end else begin
          mgmt_rdata <= dev_peek(dev_page, cur.phy, cur.rg);
        end
      end else lat <= lat - 1;
    end else if (mgmt_start) begin
      mgmt_busy <= 1'b1;
      lat <= nstart % 4;
      nstart <= nstart + 1;
      cur.phy = mgmt_phy; cur.rg = mgmt_reg; cur.wd = mgmt_wdata; cur.wr = mgmt_write; cur.edge_n = cyc;
      log_q.push_back(cur);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [17:0] a, input logic [31:0] d);
    int done_cyc;
    int n;
    logic [4:0]  dphy, lo, hi;
    logic [31:0] exp_rd;
    log_q.delete();
    fall_q.delete();
    dphy = 5'h10 | {2'b00, a[8:6]};
    lo = {a[5:2], 1'b0};
    hi = {a[5:2], 1'b1};
    @(negedge clk);
    check(host_ready == 1'b1, "R7 ready before request", 32'(host_ready), 1);
    host_valid = 1'b1; host_write = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_addr = ~a; host_wdata = ~d;
    done_cyc = -1;
    for (int i = 0; i < 400; i++) begin
      if (host_done) begin done_cyc = cyc; break; end
      if (host_ready) begin check(0, "R7 ready low while busy", 1, 0); break; end
      @(negedge clk);
    end
    check(done_cyc >= 0, "R7 done seen", 32'(done_cyc), 0);
    if (done_cyc < 0) return;
    n = log_q.size();
    check(n == 3 && fall_q.size() == 3, "R8 three transactions", 32'(n), 3);
    if (n == 3 && fall_q.size() == 3) begin
      check(log_q[0].phy == 5'h18 && log_q[0].rg == 0 && log_q[0].wr && log_q[0].wd == {7'd0, a[17:9]},
            "R2 page write", {log_q[0].phy, log_q[0].rg, log_q[0].wd}, {5'h18, 5'd0, 7'd0, a[17:9]});
      check(log_q[1].edge_n - fall_q[0] == S + 2, "R3 settle gap", 32'(log_q[1].edge_n - fall_q[0]), S + 2);
      check(log_q[2].edge_n - fall_q[1] == 2, "R8 data spacing", 32'(log_q[2].edge_n - fall_q[1]), 2);
      check(log_q[1].phy == dphy && log_q[2].phy == dphy, "R4 data phy", {log_q[1].phy, log_q[2].phy}, {dphy, dphy});
      check(done_cyc == fall_q[2] + 2, "R7 done timing", 32'(done_cyc), 32'(fall_q[2] + 2));
      if (w) begin
        check(log_q[1].wr && log_q[1].rg == hi && log_q[1].wd == d[31:16], "R6 high half first",
              {log_q[1].rg, log_q[1].wd}, {hi, d[31:16]});
        check(log_q[2].wr && log_q[2].rg == lo && log_q[2].wd == d[15:0], "R6 low half second",
              {log_q[2].rg, log_q[2].wd}, {lo, d[15:0]});
        check(host_all_ones == 1'b0, "R10 no flag on write", 32'(host_all_ones), 0);
      end else begin
        exp_rd = {dev_peek(a[17:9], dphy, hi), dev_peek(a[17:9], dphy, lo)};
        check(!log_q[1].wr && log_q[1].rg == lo && !log_q[2].wr && log_q[2].rg == hi, "R4 R5 read order",
              {log_q[1].rg, log_q[2].rg}, {lo, hi});
        check(host_rdata == exp_rd, "R5 read data", host_rdata, exp_rd);
        check(host_all_ones == (exp_rd == 32'hFFFFFFFF), "R10 all ones flag", 32'(host_all_ones),
              32'(exp_rd == 32'hFFFFFFFF));
      end
    end
    @(negedge clk);
    check(host_done == 1'b0 && host_ready == 1'b1, "R7 done single pulse", {host_done, host_ready}, 32'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(host_ready == 1'b1 && host_done == 1'b0 && host_all_ones == 1'b0 && mgmt_start == 1'b0,
          "R1 reset state", {host_ready, host_done, host_all_ones, mgmt_start}, 32'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b1, 18'h2A5C8, 32'hDEADBEEF);
    access(1'b0, 18'h2A5CB, 32'h0);            // R11 low bits differ
    access(1'b0, 18'h2A5C8, 32'h0);
    check(host_rdata == 32'hDEADBEEF, "R11 address bits 1:0 ignored", host_rdata, 32'hDEADBEEF);
    access(1'b0, 18'h00000, 32'h0);
    access(1'b1, {9'h0AB, 3'd7, 4'hF, 2'b00}, 32'h1234_5678);
    access(1'b0, {9'h0AB, 3'd7, 4'hF, 2'b11}, 32'h0);
    check(host_rdata == 32'h1234_5678, "R5 R11 readback", host_rdata, 32'h1234_5678);
    access(1'b0, {9'h1FF, 3'd2, 4'h3, 2'b00}, 32'h0);
    check(host_all_ones == 1'b0, "R10 flag clears after done", 32'(host_all_ones), 0);
    access(1'b1, {9'h155, 3'd0, 4'h0, 2'b01}, 32'hFFFF_0000);
    access(1'b0, {9'h155, 3'd0, 4'h0, 2'b00}, 32'h0);
    access(1'b0, {9'h155, 3'd5, 4'h9, 2'b00}, 32'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule